// File: doc/BRIEF.md
# Big-Endian Byte-Lane Load/Store Unit

This unit sits between a processor core and a data memory that is one 32-bit word wide and addressed by bytes. For a store it turns a byte address, an access size and a register value into a word address, a per-byte write enable and a write word. The register's low byte or halfword is repeated onto every lane that could receive it. For a load it raises a read enable for the word. When the memory returns the word, it picks out the addressed byte or halfword and widens it to 32 bits, either by sign or by zeros.

Lanes follow big-endian order. The byte at the lowest address of a word is the most significant one. Halfword and word accesses must be naturally aligned. A misaligned request raises an error and reaches the memory with no write enables and no read enable. One load may be outstanding: the unit keeps the load's offset, size and signedness until the data-valid strobe arrives.

Top module: `be_lane_lsu`

## Requirements
- R1: The word address output equals the access address with its two low bits dropped, for every size and direction.
- R2: An aligned byte store at offset k (0..3) sets only write-enable bit 3-k, and the write word carries register bits 7:0 in all four byte lanes.
- R3: A halfword store at offset 0 drives write enables 4'b1100, and at offset 2 drives 4'b0011. Either way the write word holds register bits 15:0 in both halves.
- R4: A word store drives write enables 4'b1111, and the write word equals the register value.
- R5: Size encoding is 00 byte, 01 halfword, 10 word, 11 reserved. A halfword with address bit 0 set, a word with either low address bit set, or a reserved size raises the error output while the request is valid. In that case the write enables are all zero and the read enable stays low. A byte access never raises the error.
- R6: A signed byte load at offset k returns memory bits [31-8k:24-8k] sign-extended. A signed halfword load returns bits 31:16 at offset 0 and bits 15:0 at offset 2, sign-extended.
- R7: An unsigned byte or halfword load returns the same selected bits as R6, with zeros above them.
- R8: A word load returns the memory word unchanged, whatever the signedness flag says.
- R9: The load-valid output is high exactly in the cycle after a cycle in which the memory data-valid strobe was high. The load result changes only on such a strobe.
- R10: An aligned load raises the read enable and drives all write enables to zero.
- R11: After reset, load-valid is 0 and the load result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request present this cycle |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_unsigned | input | 1 | Zero-extend a sub-word load |
| acc_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| acc_addr | input | 32 | Byte address |
| st_data | input | 32 | Register value to store |
| mem_addr | output | 30 | Word address |
| mem_wmask | output | 4 | Byte write enables, bit 3 = offset 0 |
| mem_wdata | output | 32 | Lane-replicated write word |
| mem_ren | output | 1 | Read enable for an aligned load |
| misalign | output | 1 | Alignment or size error on the current request |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read word |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The assertions check the following on every clock cycle: an error forces an empty write mask and no read, a valid byte store enables exactly one lane, a load never carries write enables, and the load-valid output trails the memory strobe by one cycle with the result held between strobes. Other properties can only be shown by the bench's scenarios. These are which lane a given offset reaches, the replication pattern of the write word, the bit that sign extension copies, and the fact that a load result uses the offset and size captured at issue even after the request inputs have changed.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
  import lsu_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic             req,
  input  acc_size_e        size,
  input  logic [OFF_W-1:0] off,
  output logic             err
);
  logic bad;

  always_comb begin
    unique case (size)
      SZ_BYTE: bad = 1'b0;
      SZ_HALF: bad = off[0];
      SZ_WORD: bad = |off;
      default: bad = 1'b1;
    endcase
    err = req & bad;
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic              en,
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] src,
  output logic [LANES-1:0]  wmask,
  output logic [DATA_W-1:0] wdata
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int HI = DATA_W - 1 - 8 * k;
    logic       hit;
    logic [7:0] lane_byte;

    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          hit       = (off == OFF_W'(k));
          lane_byte = src[7:0];
        end
        SZ_HALF: begin
          hit       = (off[OFF_W-1:1] == (OFF_W-1)'(k >> 1));
          lane_byte = (k % 2 == 0) ? src[15:8] : src[7:0];
        end
        SZ_WORD: begin
          hit       = 1'b1;
          lane_byte = src[HI -: 8];
        end
        default: begin
          hit       = 1'b0;
          lane_byte = src[7:0];
        end
      endcase
    end

    assign wmask[LANES-1-k] = en & hit;
    assign wdata[HI -: 8]   = lane_byte;
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rvalid,
  input  logic [DATA_W-1:0] rdata,
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic              uns,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  logic [7:0]        lane [LANES];
  logic [7:0]        b_sel;
  logic [15:0]       h_sel;
  logic [DATA_W-1:0] ext;
  logic [DATA_W-1:0] data_d, data_q;
  logic              vld_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane[k] = rdata[DATA_W-1-8*k -: 8];
  end

  always_comb begin
    b_sel = lane[off];
    h_sel = {lane[{off[OFF_W-1:1], 1'b0}], lane[{off[OFF_W-1:1], 1'b1}]};
    unique case (size)
      SZ_BYTE: ext = {{(DATA_W-8){~uns & b_sel[7]}}, b_sel};
      SZ_HALF: ext = {{(DATA_W-16){~uns & h_sel[15]}}, h_sel};
      default: ext = rdata;
    endcase
    data_d = rvalid ? ext : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= rvalid;
      data_q <= data_d;
    end
  end

  assign ld_valid = vld_q;
  assign ld_data  = data_q;

  // R9
  vld_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> ld_valid);
  // R9
  vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |=> !ld_valid);
  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |=> $stable(ld_data));
endmodule

// File: rtl/be_lane_lsu.sv
module be_lane_lsu
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  input  logic                 acc_store,
  input  logic                 acc_unsigned,
  input  logic [1:0]           acc_size,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [DATA_W-1:0]    st_data,
  output logic [ADDR_W-3:0]    mem_addr,
  output logic [DATA_W/8-1:0]  mem_wmask,
  output logic [DATA_W-1:0]    mem_wdata,
  output logic                 mem_ren,
  output logic                 misalign,
  input  logic                 mem_rvalid,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 ld_valid,
  output logic [DATA_W-1:0]    ld_data
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  acc_size_e        size_in;
  logic [OFF_W-1:0] off_in;
  logic             err;
  logic             st_en;
  logic             ld_issue;

  acc_size_e        pend_size_d, pend_size_q;
  logic [OFF_W-1:0] pend_off_d, pend_off_q;
  logic             pend_uns_d, pend_uns_q;

  assign size_in  = acc_size_e'(acc_size);
  assign off_in   = acc_addr[OFF_W-1:0];
  assign mem_addr = acc_addr[ADDR_W-1:OFF_W];
  assign st_en    = acc_valid & acc_store & ~err;
  assign ld_issue = acc_valid & ~acc_store & ~err;
  assign mem_ren  = ld_issue;
  assign misalign = err;

  lsu_align_chk #(.OFF_W(OFF_W)) u_align (
    .req  (acc_valid),
    .size (size_in),
    .off  (off_in),
    .err  (err)
  );

  lsu_store_lanes #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_st (
    .en    (st_en),
    .size  (size_in),
    .off   (off_in),
    .src   (st_data),
    .wmask (mem_wmask),
    .wdata (mem_wdata)
  );

  always_comb begin
    pend_size_d = ld_issue ? size_in      : pend_size_q;
    pend_off_d  = ld_issue ? off_in       : pend_off_q;
    pend_uns_d  = ld_issue ? acc_unsigned : pend_uns_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_size_q <= SZ_WORD;
      pend_off_q  <= '0;
      pend_uns_q  <= 1'b0;
    end else begin
      pend_size_q <= pend_size_d;
      pend_off_q  <= pend_off_d;
      pend_uns_q  <= pend_uns_d;
    end
  end

  lsu_load_extract #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_ld (
    .clk      (clk),
    .rst_n    (rst_n),
    .rvalid   (mem_rvalid),
    .rdata    (mem_rdata),
    .size     (pend_size_q),
    .off      (pend_off_q),
    .uns      (pend_uns_q),
    .ld_valid (ld_valid),
    .ld_data  (ld_data)
  );

  // R5
  err_blocks_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_wmask == '0 && !mem_ren));
  // R5
  byte_never_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_size == 2'b00) |-> !misalign);
  // R2
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_store && acc_size == 2'b00) |-> $countones(mem_wmask) == 1);
  // R10
  load_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ren |-> mem_wmask == '0);
endmodule

// File: tb/sim_be_lane_lsu.sv
module sim_be_lane_lsu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_store = 1'b0, acc_unsigned = 1'b0;
  logic [1:0]  acc_size = 2'b00;
  logic [31:0] acc_addr = '0, st_data = '0;
  logic [29:0] mem_addr;
  logic [3:0]  mem_wmask;
  logic [31:0] mem_wdata;
  logic        mem_ren, misalign;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        ld_valid;
  logic [31:0] ld_data;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_exp = '0;

  always #2 clk = ~clk;

  be_lane_lsu u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_load(logic [31:0] w, logic [1:0] off, logic [1:0] sz, logic uns);
    logic [7:0]  b;
    logic [15:0] h;
    b = 8'((w >> (24 - 8 * off)) & 32'hff);
    h = off[1] ? w[15:0] : w[31:16];
    case (sz)
      2'b00:   return uns ? {24'h0, b} : {{24{b[7]}}, b};
      2'b01:   return uns ? {16'h0, h} : {{16{h[15]}}, h};
      default: return w;
    endcase
  endfunction

  task automatic do_store(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] v,
                          input logic [3:0] e_mask, input logic [31:0] e_data, input logic e_err,
                          input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_store = 1'b1; acc_size = sz; acc_addr = a; st_data = v;
    #1;
    chk(mem_addr == a[31:2], "R1 word address", {2'b0, mem_addr}, {2'b0, a[31:2]});
    chk(misalign == e_err, {req, " error flag"}, {31'b0, misalign}, {31'b0, e_err});
    chk(mem_wmask == e_mask, {req, " write mask"}, {28'b0, mem_wmask}, {28'b0, e_mask});
    if (!e_err) chk(mem_wdata == e_data, {req, " write data"}, mem_wdata, e_data);
    @(negedge clk);
    acc_valid = 1'b0; acc_store = 1'b0;
  endtask

  task automatic do_load(input logic [31:0] a, input logic [1:0] sz, input logic uns,
                         input logic [31:0] w, input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_store = 1'b0; acc_size = sz; acc_addr = a; acc_unsigned = uns;
    #1;
    chk(mem_ren && mem_wmask == 4'b0, "R10 load read enable", {27'b0, mem_ren, mem_wmask}, 32'h10);
    @(negedge clk);
    acc_valid = 1'b0; acc_addr = 32'hFFFF_FFFF; acc_size = 2'b11; acc_unsigned = ~uns;
    mem_rvalid = 1'b1; mem_rdata = w;
    exp_q.push_back(model_load(w, a[1:0], sz, uns));
    tag_q.push_back(req);
    @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = 32'h5A5A_5A5A;
  endtask

  // Monitor: R9 one-cycle latency is implied by popping exactly when ld_valid is high
  always @(negedge clk) begin
    if (rst_n && ld_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected load valid", ld_data, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_exp = e;
        chk(ld_data == e, t, ld_data, e);
      end
    end
  end

  initial begin
    #(4 * 200000);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(ld_valid == 1'b0, "R11 reset valid", {31'b0, ld_valid}, 32'h0);
    chk(ld_data == 32'h0, "R11 reset data", ld_data, 32'h0);
    rst_n = 1'b1;

    // R2 byte stores at each offset
    for (int k = 0; k < 4; k++)
      do_store(32'h0000_1000 + k, 2'b00, 32'hA1B2_C3D4, 4'(1 << (3 - k)), 32'hD4D4_D4D4, 1'b0, "R2 byte store");
    do_store(32'h0000_2003, 2'b00, 32'h0000_0077, 4'b0001, 32'h7777_7777, 1'b0, "R2 byte store");
    // R3 halfword stores
    do_store(32'h0000_3000, 2'b01, 32'hA1B2_C3D4, 4'b1100, 32'hC3D4_C3D4, 1'b0, "R3 half store off0");
    do_store(32'h0000_3002, 2'b01, 32'hA1B2_C3D4, 4'b0011, 32'hC3D4_C3D4, 1'b0, "R3 half store off2");
    // R4 word store
    do_store(32'hFFFF_FFFC, 2'b10, 32'hA1B2_C3D4, 4'b1111, 32'hA1B2_C3D4, 1'b0, "R4 word store");
    // R5 misaligned cases
    do_store(32'h0000_4001, 2'b01, 32'h1234_5678, 4'b0000, 32'h0, 1'b1, "R5 half odd");
    do_store(32'h0000_4003, 2'b01, 32'h1234_5678, 4'b0000, 32'h0, 1'b1, "R5 half odd");
    do_store(32'h0000_4002, 2'b10, 32'h1234_5678, 4'b0000, 32'h0, 1'b1, "R5 word off2");
    do_store(32'h0000_4001, 2'b10, 32'h1234_5678, 4'b0000, 32'h0, 1'b1, "R5 word off1");
    do_store(32'h0000_4000, 2'b11, 32'h1234_5678, 4'b0000, 32'h0, 1'b1, "R5 reserved size");

    // R5 misaligned load: no read enable
    @(negedge clk);
    acc_valid = 1'b1; acc_store = 1'b0; acc_size = 2'b10; acc_addr = 32'h0000_5006;
    #1;
    chk(misalign && !mem_ren && mem_wmask == 4'b0, "R5 misaligned load",
        {27'b0, misalign, mem_ren, mem_wmask}, 32'h20);
    @(negedge clk);
    acc_valid = 1'b0;

    // R6 signed byte loads at each offset
    for (int k = 0; k < 4; k++)
      do_load(32'h0000_6000 + k, 2'b00, 1'b0, 32'h80_7F_C3_11, "R6 signed byte load");
    // R7 unsigned byte loads
    for (int k = 0; k < 4; k++)
      do_load(32'h0000_6000 + k, 2'b00, 1'b1, 32'h80_7F_C3_11, "R7 unsigned byte load");
    // R6 / R7 halfword loads
    do_load(32'h0000_7000, 2'b01, 1'b0, 32'h8001_7FFE, "R6 signed half off0");
    do_load(32'h0000_7002, 2'b01, 1'b0, 32'h8001_F00D, "R6 signed half off2");
    do_load(32'h0000_7000, 2'b01, 1'b1, 32'h8001_7FFE, "R7 unsigned half off0");
    do_load(32'h0000_7002, 2'b01, 1'b1, 32'h0001_F00D, "R7 unsigned half off2");
    // R8 word loads ignore signedness
    do_load(32'h0000_8000, 2'b10, 1'b0, 32'hDEAD_BEEF, "R8 word load");
    do_load(32'h0000_8004, 2'b10, 1'b1, 32'h8765_4321, "R8 word load");

    // R9 result held while no strobe arrives
    repeat (4) @(negedge clk);
    chk(ld_valid == 1'b0, "R9 valid low without strobe", {31'b0, ld_valid}, 32'h0);
    chk(ld_data == last_exp, "R9 data held", ld_data, last_exp);
    chk(exp_q.size() == 0, "R9 all results delivered", 32'(exp_q.size()), 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule